// File: doc/BRIEF.md
# AXI ID Masked Event Qualifier

This block decides, cycle by cycle, whether activity on an AXI port counts toward a filtered performance event. It watches the read and write handshakes and their transaction IDs. For each counter of a small counter bank, it produces a one-cycle qualify pulse. A pulse is raised only when the counter's event code selects ID-filtered reads or ID-filtered writes, and the observed ID matches a programmed value under a programmed mask. A mask bit of 1 makes that ID bit take part in the comparison.

The block has two modes. In shared mode, a single ID/mask pair serves every counter, and only address-channel handshakes are counted. In per-counter mode, counters 1 and above each take their own ID, mask, port select and channel select. The channel select chooses between counting address handshakes and counting data beats. Counter 0 always keeps the shared address-channel setting.

The W channel carries no ID. Write data beats are therefore paired with the IDs of accepted write addresses, which are held in arrival order in a small pending store.

Top module: `axid_event_qualifier`

## Requirements
- R1: An ID matches when (observed ID AND mask) equals (programmed ID AND mask). A mask bit of 1 takes part in the comparison; a mask bit of 0 is ignored.
- R2: A counter pulses only when its 8-bit event code is 0x41 (filtered reads) or 0x42 (filtered writes). Any other code never produces a pulse.
- R3: With `per_cnt_mode`=0, every counter uses `shared_id`/`shared_mask` and counts address handshakes: one pulse per ARVALID&ARREADY for code 0x41, and one per AWVALID&AWREADY for code 0x42. Channel and port selects are ignored in this mode.
- R4: Counter 0 uses the shared setting and the address channel even when `per_cnt_mode`=1.
- R5: With `per_cnt_mode`=1, counter k≥1 uses its own ID and mask, taken from bits [k*ID_W +: ID_W] of `cnt_id` and `cnt_mask`.
- R6: In per-counter mode, `cnt_chan[k]`=0 counts address handshakes. `cnt_chan[k]`=1 counts data beats: one pulse per RVALID&RREADY, matched on `r_id`, for 0x41, and one per WVALID&WREADY for 0x42.
- R7: A W beat is matched against the ID of the oldest pending accepted write address. That ID is retired by the beat with `w_last`=1. When no address is pending, an AW handshake in the same cycle supplies the ID.
- R8: In per-counter mode, a counter whose port select `cnt_port[k*PORT_W +: PORT_W]` is non-zero never pulses.
- R9: `cnt_pulse[k]` is registered. It is high in the cycle after the qualifying handshake, and all bits are 0 during reset.
- R10: Up to PEND_DEPTH write IDs are held pending. A W beat with no pending address and no AW handshake in the same cycle does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | ID_W | Read data ID |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Last beat of a write burst |
| per_cnt_mode | input | 1 | 0 = shared filter, 1 = per-counter filter |
| shared_id | input | ID_W | Shared ID compare value |
| shared_mask | input | ID_W | Shared mask (1 = bit compared) |
| ev_code | input | NCNT*8 | Event code per counter |
| cnt_id | input | NCNT*ID_W | Per-counter ID value (slot 0 unused) |
| cnt_mask | input | NCNT*ID_W | Per-counter mask (slot 0 unused) |
| cnt_chan | input | NCNT | Per-counter channel select (bit 0 unused) |
| cnt_port | input | NCNT*PORT_W | Per-counter port select, must be 0 to count |
| cnt_pulse | output | NCNT | Qualified count pulse per counter |

## Verification
The only internal state is the pending write-ID store. A slipped read or write pointer, or a wrong occupancy count, shows up on the next W beat of a data-channel write counter. The beat is then matched against the wrong ID and the pulse appears or vanishes one cycle after that beat. A long random mix of interleaved AW and W traffic, checked every cycle against an ordered model, exposes such a fault within a few bursts. Errors in the compare and gating logic show immediately, one cycle after the offending handshake.

// File: rtl/axid_event_qualifier.sv
module axid_event_qualifier #(
  parameter int ID_W       = 4,
  parameter int NCNT       = 4,
  parameter int PEND_DEPTH = 4,
  parameter int PORT_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ar_valid,
  input  logic                   ar_ready,
  input  logic [ID_W-1:0]        ar_id,
  input  logic                   aw_valid,
  input  logic                   aw_ready,
  input  logic [ID_W-1:0]        aw_id,
  input  logic                   r_valid,
  input  logic                   r_ready,
  input  logic [ID_W-1:0]        r_id,
  input  logic                   w_valid,
  input  logic                   w_ready,
  input  logic                   w_last,
  input  logic                   per_cnt_mode,
  input  logic [ID_W-1:0]        shared_id,
  input  logic [ID_W-1:0]        shared_mask,
  input  logic [NCNT*8-1:0]      ev_code,
  input  logic [NCNT*ID_W-1:0]   cnt_id,
  input  logic [NCNT*ID_W-1:0]   cnt_mask,
  input  logic [NCNT-1:0]        cnt_chan,
  input  logic [NCNT*PORT_W-1:0] cnt_port,
  output logic [NCNT-1:0]        cnt_pulse
);
  localparam int PW = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;
  localparam logic [7:0] CODE_RD = 8'h41;
  localparam logic [7:0] CODE_WR = 8'h42;
  localparam logic [PW:0] FULL = (PW+1)'(PEND_DEPTH);

  logic ar_hs, aw_hs, r_hs, w_hs;
  assign ar_hs = ar_valid && ar_ready;
  assign aw_hs = aw_valid && aw_ready;
  assign r_hs  = r_valid && r_ready;
  assign w_hs  = w_valid && w_ready;

  logic [ID_W-1:0] pend_q [PEND_DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [PW:0]     pend_cnt;
  logic            pend_have, push, pop;
  logic [ID_W-1:0] head_id;

  assign pend_have = (pend_cnt != '0) || aw_hs;
  assign head_id   = (pend_cnt != '0) ? pend_q[rd_ptr] : aw_id;
  assign pop       = w_hs && w_last && pend_have;
  assign push      = aw_hs && ((pend_cnt < FULL) || pop);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(PEND_DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) if (push) pend_q[wr_ptr] <= aw_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      pend_cnt <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      pend_cnt <= pend_cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  p_store_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= FULL);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == FULL && !pop) |=> $stable(wr_ptr));

  function automatic logic id_hit(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b,
                                  input logic [ID_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    logic            per, is_rd, is_wr, chan, port_ok, hit;
    logic [ID_W-1:0] ref_id, ref_mask;
    logic [7:0]      code;

    assign code     = ev_code[k*8 +: 8];
    assign per      = per_cnt_mode && (k != 0);
    assign is_rd    = code == CODE_RD;
    assign is_wr    = code == CODE_WR;
    assign ref_id   = per ? cnt_id[k*ID_W +: ID_W]   : shared_id;
    assign ref_mask = per ? cnt_mask[k*ID_W +: ID_W] : shared_mask;
    assign chan     = per && cnt_chan[k];
    assign port_ok  = !per || (cnt_port[k*PORT_W +: PORT_W] == '0);

    always_comb begin
      hit = 1'b0;
      if (port_ok) begin
        if (is_rd)
          hit = chan ? (r_hs && id_hit(r_id, ref_id, ref_mask))
                     : (ar_hs && id_hit(ar_id, ref_id, ref_mask));
        else if (is_wr)
          hit = chan ? (w_hs && pend_have && id_hit(head_id, ref_id, ref_mask))
                     : (aw_hs && id_hit(aw_id, ref_id, ref_mask));
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt_pulse[k] <= 1'b0;
      else        cnt_pulse[k] <= hit;

    p_pulse_needs_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse[k] |-> $past(ar_hs || aw_hs || r_hs || w_hs));
    p_code_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (code != CODE_RD && code != CODE_WR) |=> !cnt_pulse[k]);
    if (k != 0) begin : g_port
      p_port_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cnt_mode && cnt_port[k*PORT_W +: PORT_W] != '0) |=> !cnt_pulse[k]);
    end else begin : g_zero
      p_cnt0_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_pulse[0] |-> $past(ar_hs || aw_hs));
    end
  end
endmodule

// File: tb/sim_axid_event_qualifier.sv
module sim_axid_event_qualifier;
  localparam int IDW = 4, N = 4, D = 4, PW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic ar_valid, ar_ready, aw_valid, aw_ready, r_valid, r_ready, w_valid, w_ready, w_last;
  logic [IDW-1:0] ar_id, aw_id, r_id, shared_id, shared_mask;
  logic per_cnt_mode;
  logic [N*8-1:0]   ev_code;
  logic [N*IDW-1:0] cnt_id, cnt_mask;
  logic [N-1:0]     cnt_chan;
  logic [N*PW-1:0]  cnt_port;
  logic [N-1:0]     cnt_pulse;

  axid_event_qualifier #(.ID_W(IDW), .NCNT(N), .PEND_DEPTH(D), .PORT_W(PW)) u0 (
    .clk, .rst_n, .ar_valid, .ar_ready, .ar_id, .aw_valid, .aw_ready, .aw_id,
    .r_valid, .r_ready, .r_id, .w_valid, .w_ready, .w_last, .per_cnt_mode,
    .shared_id, .shared_mask, .ev_code, .cnt_id, .cnt_mask, .cnt_chan, .cnt_port,
    .cnt_pulse);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [IDW-1:0] q[$];

  function automatic logic mt(input logic [IDW-1:0] a, input logic [IDW-1:0] b,
                              input logic [IDW-1:0] m);
    return (a & m) == (b & m);
  endfunction

  function automatic logic [N-1:0] model();
    logic [N-1:0] e = '0;
    for (int k = 0; k < N; k++) begin
      logic [7:0] c = ev_code[k*8 +: 8];
      logic per = per_cnt_mode && k != 0;
      logic [IDW-1:0] rid = per ? cnt_id[k*IDW +: IDW] : shared_id;
      logic [IDW-1:0] rm  = per ? cnt_mask[k*IDW +: IDW] : shared_mask;
      logic ch = per && cnt_chan[k];
      logic wok;
      logic [IDW-1:0] wid;
      if (q.size() > 0) begin wok = 1; wid = q[0]; end
      else begin wok = aw_valid && aw_ready; wid = aw_id; end
      if (per && cnt_port[k*PW +: PW] != 0) e[k] = 0;
      else if (c == 8'h41)
        e[k] = ch ? (r_valid && r_ready && mt(r_id, rid, rm))
                  : (ar_valid && ar_ready && mt(ar_id, rid, rm));
      else if (c == 8'h42)
        e[k] = ch ? (w_valid && w_ready && wok && mt(wid, rid, rm))
                  : (aw_valid && aw_ready && mt(aw_id, rid, rm));
    end
    return e;
  endfunction

  task automatic tick(input string tag);
    logic [N-1:0] e = model();
    if (aw_valid && aw_ready) q.push_back(aw_id);
    if (w_valid && w_ready && w_last && q.size() > 0) void'(q.pop_front());
    @(posedge clk); #1;
    n_cmp++;
    if (cnt_pulse !== e) begin
      n_bad++;
      $display("FAIL %s: cnt_pulse=%b expected=%b", tag, cnt_pulse, e);
    end
  endtask

  task automatic idle();
    {ar_valid, aw_valid, r_valid, w_valid} = '0;
  endtask

  task automatic rnd_traffic();
    ar_valid = 1'($urandom); ar_ready = 1'($urandom); ar_id = IDW'($urandom);
    aw_valid = (q.size() < D) ? 1'($urandom) : 1'b0; aw_ready = 1'($urandom);
    aw_id = IDW'($urandom);
    r_valid = 1'($urandom); r_ready = 1'($urandom); r_id = IDW'($urandom);
    w_valid = 1'($urandom); w_ready = 1'($urandom); w_last = ($urandom_range(0, 2) == 0);
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_up();
    end
  end

  initial begin
    void'($urandom(7));
    rst_n = 0; per_cnt_mode = 0; shared_id = 4'h6; shared_mask = 4'hF;
    ev_code = {8'h42, 8'h42, 8'h41, 8'h41};
    cnt_id = '0; cnt_mask = '0; cnt_chan = '1; cnt_port = '1;
    {ar_ready, aw_ready, r_ready, w_ready, w_last} = '1;
    ar_id = 4'h6; aw_id = 4'h6; r_id = 4'h6;
    {ar_valid, aw_valid, r_valid} = '1; w_valid = 1;
    // R9: outputs held low throughout reset
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      n_cmp++;
      if (cnt_pulse !== '0) begin
        n_bad++;
        $display("FAIL R9 reset: cnt_pulse=%b expected=0000", cnt_pulse);
      end
    end
    idle();
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // R1 R3: shared mask/ID sweep; channel and port selects ignored
    foreach (shared_mask_list[mi]) begin
      shared_mask = shared_mask_list[mi];
      for (int id = 0; id < 16; id++) begin
        {ar_valid, aw_valid, r_valid, w_valid, w_last} = '1;
        ar_id = IDW'(id); aw_id = IDW'(id); r_id = IDW'(id ^ 1);
        tick("R1 R3 shared");
        idle(); tick("R1 R3 idle");
      end
    end

    // R2: every event code value with random traffic
    shared_mask = 4'h0;
    for (int c = 0; c < 256; c++) begin
      ev_code = {4{8'(c)}};
      rnd_traffic();
      tick("R2 code gate");
    end

    // R4 R5 R6 R7 R9 R10: per-counter mode, random interleaved traffic
    per_cnt_mode = 1; shared_id = 4'h9; shared_mask = 4'hC; cnt_port = '0;
    ev_code = {8'h42, 8'h41, 8'h42, 8'h41};
    cnt_id   = {4'h4, 4'h0, 4'h3, 4'h0};
    cnt_mask = {4'hC, 4'h0, 4'hF, 4'h0};
    cnt_chan = 4'b0111;
    for (int i = 0; i < 2000; i++) begin
      rnd_traffic();
      tick("R4 R5 R6 R7 R10 per-counter");
    end
    cnt_mask = {4'h3, 4'h1, 4'h5, 4'h0};
    cnt_chan = 4'b1011;
    ev_code = {8'h41, 8'h42, 8'h42, 8'h42};
    for (int i = 0; i < 2000; i++) begin
      rnd_traffic();
      tick("R5 R6 R7 per-counter set2");
    end

    // R8: non-zero port selects silence counters 1 and 3
    cnt_port = {2'd2, 2'd0, 2'd1, 2'd0};
    for (int i = 0; i < 500; i++) begin
      rnd_traffic();
      tick("R8 port select");
    end
    cnt_port = '0;

    // R10: drain, then orphan W beat; R7: same-cycle AW bypass
    idle();
    while (q.size() > 0) begin
      w_valid = 1; w_ready = 1; w_last = 1;
      tick("R7 drain");
    end
    cnt_mask = '0; cnt_chan = 4'b1110; ev_code = {4{8'h42}};
    idle(); w_valid = 1; w_ready = 1; w_last = 1;
    tick("R10 orphan W beat");
    aw_valid = 1; aw_ready = 1; aw_id = 4'h3;
    tick("R7 same-cycle bypass");
    idle(); tick("R7 after bypass");

    done = 1;
    finish_up();
  end

  logic [IDW-1:0] shared_mask_list [4] = '{4'hF, 4'hC, 4'h0, 4'h5};
endmodule